// File: doc/BRIEF.md
# Power-up configuration loader

After reset this block copies start-up settings from a 256-word by 16-bit nonvolatile memory into the working register file of a larger controller. It first reads a signature word at memory address 0x37. Only when that word equals 0xAA55 is the memory treated as holding valid settings. The load then copies the block of words at 0x10–0x1F without condition, followed by the block at 0x2C–0x33. A word in the second block is copied only when its bit 15 is 1. Every copied word lands at the register whose address equals the low six bits of its memory address, with all 16 bits unchanged.

The loader drives a synchronous memory read port. It keeps one read in flight at a time and accepts a read latency of any length, which ends with a one-cycle data-valid pulse. It writes through the same port that the host uses. While the load runs, host writes are held off. Once `done_o` rises, the host owns the write port and the loader never touches the memory again until the next reset. Register writes are volatile: nothing is ever written back to the memory.

Top module: `nvm_cfg_loader`

## Requirements
- R1: While reset is applied and in the cycles after it is released, `busy_o` is 1 and `done_o` is 0. The first read issued after reset targets address 0x37.
- R2: Each read request on `mem_rd_o` lasts exactly one cycle. No new request is issued until a data-valid pulse has been received for the previous one. `mem_addr_o` holds its value while the loader waits.
- R3: If the word read at 0x37 is anything other than 0xAA55, no register is written, no further read is issued, and the load ends.
- R4: When the signature matches, each of the words at 0x10–0x1F is written to register address (memory address & 0x3F), with all 16 data bits unchanged.
- R5: When the signature matches, a word at 0x2C–0x33 is written only if its bit 15 is 1. A word whose bit 15 is 0 produces no write.
- R6: Reads occur in this fixed order: 0x37, then 0x10 through 0x1F ascending, then 0x2C through 0x33 ascending. Register writes during one load follow that ascending order, and no register is written twice.
- R7: `done_o` rises at the first clock edge after the edge that samples the final data-valid pulse: the last word of 0x33, or the failed signature. The write for that last word occupies the cycle in between. `done_o` then stays high until reset.
- R8: `busy_o` is the inverse of `done_o`. While busy, host write requests never reach the register port. Once done, `reg_we_o`, `reg_addr_o` and `reg_data_o` follow the host inputs in the same cycle.
- R9: After done, data-valid pulses cause no read and no register write.
- R10: A data-valid pulse sampled while a read request is being issued is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; starts a new load |
| mem_rd_o | output | 1 | One-cycle memory read request |
| mem_addr_o | output | 8 | Memory word address |
| mem_valid_i | input | 1 | One-cycle read data valid |
| mem_data_i | input | 16 | Memory read data |
| host_we_i | input | 1 | Host register write enable |
| host_addr_i | input | 6 | Host register address |
| host_data_i | input | 16 | Host register write data |
| reg_we_o | output | 1 | Register file write enable |
| reg_addr_o | output | 6 | Register file address |
| reg_data_o | output | 16 | Register file write data |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Load finished or skipped |

## Verification
If the step counter or the state goes wrong, the read address sequence departs from the expected list on the very next request, so the error is visible within one memory latency. A wrong decision about the signature or about bit 15 shows up as a write that should not happen, or a missing one, in the cycle after the matching data-valid. Errors in end-of-load timing or in the host arbitration appear as `done_o` moving one cycle off the expected edge, or as host writes reaching the register port while busy.

// File: rtl/nvm_ld_pkg.sv
package nvm_ld_pkg;
  typedef enum logic [2:0] {
    LD_START,
    LD_ISSUE,
    LD_WAIT,
    LD_FLUSH,
    LD_DONE
  } ld_state_e;
endpackage

// File: rtl/nvm_ld_addr_gen.sv
module nvm_ld_addr_gen #(
  parameter int unsigned          MEM_AW   = 8,
  parameter int unsigned          SW       = 5,
  parameter logic [MEM_AW-1:0]    SIG_ADDR = 8'h37,
  parameter logic [MEM_AW-1:0]    UNC_BASE = 8'h10,
  parameter int unsigned          UNC_CNT  = 16,
  parameter logic [MEM_AW-1:0]    CND_BASE = 8'h2C,
  parameter int unsigned          CND_CNT  = 8
) (
  input  logic [SW-1:0]     step_i,
  output logic [MEM_AW-1:0] addr_o,
  output logic              is_sig_o,
  output logic              is_cond_o,
  output logic              is_last_o
);
  localparam int unsigned LAST = UNC_CNT + CND_CNT;

  assign is_sig_o  = (step_i == '0);
  assign is_last_o = (int'(step_i) == int'(LAST));

  generate
    if (CND_CNT == 0) begin : g_no_cond
      assign is_cond_o = 1'b0;
    end else begin : g_cond
      assign is_cond_o = (int'(step_i) > int'(UNC_CNT));
    end
  endgenerate

  always_comb begin
    if (is_sig_o)
      addr_o = SIG_ADDR;
    else if (!is_cond_o)
      addr_o = MEM_AW'(int'(UNC_BASE) + int'(step_i) - 1);
    else
      addr_o = MEM_AW'(int'(CND_BASE) + int'(step_i) - 1 - int'(UNC_CNT));
  end
endmodule

// File: rtl/nvm_ld_fsm.sv
module nvm_ld_fsm
  import nvm_ld_pkg::*;
#(
  parameter int unsigned          MEM_AW   = 8,
  parameter int unsigned          DW       = 16,
  parameter int unsigned          REG_AW   = 6,
  parameter int unsigned          FLAG_BIT = 15,
  parameter logic [DW-1:0]        SIG_VAL  = 16'hAA55,
  parameter logic [MEM_AW-1:0]    SIG_ADDR = 8'h37,
  parameter logic [MEM_AW-1:0]    UNC_BASE = 8'h10,
  parameter int unsigned          UNC_CNT  = 16,
  parameter logic [MEM_AW-1:0]    CND_BASE = 8'h2C,
  parameter int unsigned          CND_CNT  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              mem_rd_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [DW-1:0]     mem_data_i,
  output logic              ld_we_o,
  output logic [REG_AW-1:0] ld_addr_o,
  output logic [DW-1:0]     ld_data_o,
  output logic              done_o
);
  localparam int unsigned STEPS = 1 + UNC_CNT + CND_CNT;
  localparam int unsigned SW    = $clog2(STEPS);

  ld_state_e         state_q;
  logic [SW-1:0]     step_q;
  logic              sig_ok_q;
  logic              wr_en_q;
  logic [REG_AW-1:0] wr_addr_q;
  logic [DW-1:0]     wr_data_q;
  logic              is_sig, is_cond, is_last;

  nvm_ld_addr_gen #(
    .MEM_AW(MEM_AW), .SW(SW), .SIG_ADDR(SIG_ADDR),
    .UNC_BASE(UNC_BASE), .UNC_CNT(UNC_CNT),
    .CND_BASE(CND_BASE), .CND_CNT(CND_CNT)
  ) u_addr (
    .step_i(step_q), .addr_o(mem_addr_o),
    .is_sig_o(is_sig), .is_cond_o(is_cond), .is_last_o(is_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= LD_START;
      step_q    <= '0;
      sig_ok_q  <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= 1'b0;
      unique case (state_q)
        LD_START: state_q <= LD_ISSUE;
        LD_ISSUE: state_q <= LD_WAIT;
        LD_WAIT: if (mem_valid_i) begin
          if (is_sig) begin
            if (mem_data_i == SIG_VAL) begin
              sig_ok_q <= 1'b1;
              step_q   <= step_q + SW'(1);
              state_q  <= LD_ISSUE;
            end else begin
              state_q  <= LD_FLUSH;
            end
          end else begin
            wr_en_q   <= !is_cond || mem_data_i[FLAG_BIT];
            wr_addr_q <= mem_addr_o[REG_AW-1:0];
            wr_data_q <= mem_data_i;
            if (is_last) state_q <= LD_FLUSH;
            else begin
              step_q  <= step_q + SW'(1);
              state_q <= LD_ISSUE;
            end
          end
        end
        LD_FLUSH: state_q <= LD_DONE;
        default:  state_q <= LD_DONE;
      endcase
    end
  end

  assign mem_rd_o  = (state_q == LD_ISSUE);
  assign done_o    = (state_q == LD_DONE);
  assign ld_we_o   = wr_en_q;
  assign ld_addr_o = wr_addr_q;
  assign ld_data_o = wr_data_q;

  p_rd_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);
  p_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == LD_WAIT) |-> $stable(mem_addr_o));
  p_write_needs_sig_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_q |-> sig_ok_q);
  p_cond_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_q && int'(wr_addr_q) >= int'(CND_BASE[REG_AW-1:0])
             && int'(wr_addr_q) <  int'(CND_BASE[REG_AW-1:0]) + int'(CND_CNT))
      |-> wr_data_q[FLAG_BIT]);
  p_done_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  p_idle_after_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!mem_rd_o && !wr_en_q));
endmodule

// File: rtl/nvm_ld_wr_mux.sv
module nvm_ld_wr_mux #(
  parameter int unsigned REG_AW  = 6,
  parameter int unsigned DW      = 16,
  parameter int unsigned UNC_LO  = 16,
  parameter int unsigned UNC_CNT = 16,
  parameter int unsigned CND_LO  = 44,
  parameter int unsigned CND_CNT = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              ld_we_i,
  input  logic [REG_AW-1:0] ld_addr_i,
  input  logic [DW-1:0]     ld_data_i,
  input  logic              host_we_i,
  input  logic [REG_AW-1:0] host_addr_i,
  input  logic [DW-1:0]     host_data_i,
  output logic              reg_we_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [DW-1:0]     reg_data_o
);
  assign reg_we_o   = busy_i ? ld_we_i   : host_we_i;
  assign reg_addr_o = busy_i ? ld_addr_i : host_addr_i;
  assign reg_data_o = busy_i ? ld_data_i : host_data_i;

  // order tracker for the load-phase checks
  logic              seen_q;
  logic [REG_AW-1:0] last_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (busy_i && reg_we_o) begin
      seen_q <= 1'b1;
      last_q <= reg_addr_o;
    end
  end

  p_load_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && reg_we_o) |->
      ((int'(reg_addr_o) >= int'(UNC_LO) && int'(reg_addr_o) < int'(UNC_LO + UNC_CNT)) ||
       (int'(reg_addr_o) >= int'(CND_LO) && int'(reg_addr_o) < int'(CND_LO + CND_CNT))));
  p_ascending_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && reg_we_o && seen_q) |-> (reg_addr_o > last_q));
endmodule

// File: rtl/nvm_cfg_loader.sv
module nvm_cfg_loader #(
  parameter int unsigned          MEM_AW   = 8,
  parameter int unsigned          DW       = 16,
  parameter int unsigned          REG_AW   = 6,
  parameter int unsigned          FLAG_BIT = 15,
  parameter logic [DW-1:0]        SIG_VAL  = 16'hAA55,
  parameter logic [MEM_AW-1:0]    SIG_ADDR = 8'h37,
  parameter logic [MEM_AW-1:0]    UNC_BASE = 8'h10,
  parameter int unsigned          UNC_CNT  = 16,
  parameter logic [MEM_AW-1:0]    CND_BASE = 8'h2C,
  parameter int unsigned          CND_CNT  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              mem_rd_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [DW-1:0]     mem_data_i,
  input  logic              host_we_i,
  input  logic [REG_AW-1:0] host_addr_i,
  input  logic [DW-1:0]     host_data_i,
  output logic              reg_we_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [DW-1:0]     reg_data_o,
  output logic              busy_o,
  output logic              done_o
);
  logic              ld_we;
  logic [REG_AW-1:0] ld_addr;
  logic [DW-1:0]     ld_data;

  nvm_ld_fsm #(
    .MEM_AW(MEM_AW), .DW(DW), .REG_AW(REG_AW), .FLAG_BIT(FLAG_BIT),
    .SIG_VAL(SIG_VAL), .SIG_ADDR(SIG_ADDR),
    .UNC_BASE(UNC_BASE), .UNC_CNT(UNC_CNT),
    .CND_BASE(CND_BASE), .CND_CNT(CND_CNT)
  ) u_fsm (
    .clk_i, .rst_ni, .mem_rd_o, .mem_addr_o, .mem_valid_i, .mem_data_i,
    .ld_we_o(ld_we), .ld_addr_o(ld_addr), .ld_data_o(ld_data), .done_o
  );

  assign busy_o = !done_o;

  nvm_ld_wr_mux #(
    .REG_AW(REG_AW), .DW(DW),
    .UNC_LO(int'(UNC_BASE[REG_AW-1:0])), .UNC_CNT(UNC_CNT),
    .CND_LO(int'(CND_BASE[REG_AW-1:0])), .CND_CNT(CND_CNT)
  ) u_mux (
    .clk_i, .rst_ni, .busy_i(busy_o),
    .ld_we_i(ld_we), .ld_addr_i(ld_addr), .ld_data_i(ld_data),
    .host_we_i, .host_addr_i, .host_data_i,
    .reg_we_o, .reg_addr_o, .reg_data_o
  );

  p_busy_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o != done_o);
endmodule

// File: tb/sim_nvm_cfg_loader.sv
module sim_nvm_cfg_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_rd;
  logic [7:0]  mem_addr;
  logic        mem_valid = 1'b0;
  logic [15:0] mem_data = '0;
  logic        host_we = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [15:0] host_data = '0;
  logic        reg_we;
  logic [5:0]  reg_addr;
  logic [15:0] reg_data;
  logic        busy, done;

  always #2 clk = ~clk;

  nvm_cfg_loader u0 (
    .clk_i(clk), .rst_ni(rst_n), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr),
    .mem_valid_i(mem_valid), .mem_data_i(mem_data),
    .host_we_i(host_we), .host_addr_i(host_addr), .host_data_i(host_data),
    .reg_we_o(reg_we), .reg_addr_o(reg_addr), .reg_data_o(reg_data),
    .busy_o(busy), .done_o(done)
  );

  int tests = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  logic [15:0] mem [256];
  // responder / monitor state
  bit   pend, inject, post_inject;
  int   cnt, last_valid_cyc, done_cyc, overlap;
  logic [7:0]  pend_addr;
  logic [7:0]  rd_log [64];
  int   nrd;
  logic [5:0]  wa_log [64];
  logic [15:0] wd_log [64];
  int   nwr;
  logic [7:0]  exp_rd [64];
  int   nexp_rd;
  logic [5:0]  exp_wa [64];
  logic [15:0] exp_wd [64];
  int   nexp_wr;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic void build_exp();
    nexp_rd = 1; exp_rd[0] = 8'h37; nexp_wr = 0;
    if (mem[8'h37] != 16'hAA55) return;
    for (int a = 8'h10; a <= 8'h1F; a++) begin
      exp_rd[nexp_rd++] = 8'(a);
      exp_wa[nexp_wr] = 6'(a); exp_wd[nexp_wr++] = mem[a];
    end
    for (int a = 8'h2C; a <= 8'h33; a++) begin
      exp_rd[nexp_rd++] = 8'(a);
      if (mem[a][15]) begin
        exp_wa[nexp_wr] = 6'(a); exp_wd[nexp_wr++] = mem[a];
      end
    end
  endfunction

  always @(negedge clk) begin
    mem_valid = 1'b0;
    if (rst_n) begin
      if (post_inject) begin
        mem_valid = 1'b1; mem_data = 16'hAA55;
      end
      if (pend) begin
        cnt--;
        if (cnt == 0) begin
          pend = 1'b0; mem_valid = 1'b1; mem_data = mem[pend_addr];
          last_valid_cyc = cyc;
        end
      end
      if (mem_rd) begin
        if (pend) overlap++;
        if (nrd < 64) rd_log[nrd] = mem_addr;
        nrd++;
        if (inject) begin
          mem_valid = 1'b1; mem_data = 16'h0000;
        end
        pend = 1'b1; pend_addr = mem_addr; cnt = 1 + int'($urandom % 3);
      end
      if (busy && reg_we) begin
        if (nwr < 64) begin wa_log[nwr] = reg_addr; wd_log[nwr] = reg_data; end
        nwr++;
      end
      if (done && done_cyc < 0) done_cyc = cyc;
    end
  end

  task automatic run_trial(input bit sig_good, input int mode, input bit inj, input string tag);
    logic [15:0] v;
    bit ok;
    for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
    for (int a = 8'h2C; a <= 8'h33; a++)
      if (mode == 0) mem[a][15] = 1'b0; else if (mode == 1) mem[a][15] = 1'b1;
    if (sig_good) mem[8'h37] = 16'hAA55;
    else begin
      v = 16'($urandom);
      if (v == 16'hAA55) v = 16'h55AA;
      mem[8'h37] = v;
    end
    build_exp();
    @(negedge clk);
    rst_n = 1'b0;
    pend = 0; inject = inj; post_inject = 0; nrd = 0; nwr = 0; overlap = 0;
    done_cyc = -1; last_valid_cyc = -100;
    host_we = 1'b1; host_addr = 6'h3F; host_data = 16'hDEAD;
    #1;
    chk(busy && !done, {"R1 reset state ", tag}, {busy, done}, 2'b10);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(busy && !done, {"R1 after release ", tag}, {busy, done}, 2'b10);
    for (int w = 0; w < 3000 && !done; w++) @(negedge clk);
    #1;
    chk(done, {"R7 load finished ", tag}, done, 1);
    // R1 R6 read sequence
    ok = (nrd == nexp_rd);
    for (int i = 0; i < nexp_rd && ok; i++) ok = (rd_log[i] == exp_rd[i]);
    chk(ok, {"R6 read order ", tag}, nrd, nexp_rd);
    chk(rd_log[0] == 8'h37, {"R1 first read addr ", tag}, rd_log[0], 8'h37);
    chk(overlap == 0, {"R2 one read in flight ", tag}, overlap, 0);
    // R3 R4 R5 write list (host writes to 0x3F must not appear: R8)
    ok = (nwr == nexp_wr);
    for (int i = 0; i < nexp_wr && ok; i++)
      ok = (wa_log[i] == exp_wa[i]) && (wd_log[i] == exp_wd[i]);
    if (!sig_good) chk(ok, {"R3 no writes on bad signature ", tag}, nwr, nexp_wr);
    else chk(ok, {"R4 R5 copied words ", tag}, nwr, nexp_wr);
    chk(done_cyc - last_valid_cyc == 2, {"R7 done timing ", tag}, done_cyc - last_valid_cyc, 2);
    // R8 host pass-through after done
    host_we = 1'b1; host_addr = 6'($urandom); host_data = 16'($urandom);
    #1;
    chk(reg_we && reg_addr == host_addr && reg_data == host_data && !busy,
        {"R8 host pass-through ", tag}, {reg_we, reg_addr, reg_data}, {1'b1, host_addr, host_data});
    host_we = 1'b0;
    // R9 stray valid after done
    @(negedge clk); post_inject = 1;
    @(negedge clk); post_inject = 0;
    ok = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      if (mem_rd || reg_we || !done) ok = 0;
    end
    chk(ok, {"R9 idle after done ", tag}, {mem_rd, reg_we, done}, 3'b001);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    run_trial(1'b0, 2, 1'b0, "bad sig");
    run_trial(1'b1, 0, 1'b0, "flags clear");
    run_trial(1'b1, 1, 1'b0, "flags set");
    run_trial(1'b1, 2, 1'b1, "R10 stray valid at issue");
    run_trial(1'b0, 1, 1'b1, "R10 bad sig with stray valid");
    for (int t = 0; t < 20; t++)
      run_trial(($urandom % 2) == 0, 2, ($urandom % 4) == 0, "random");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule